// File: doc/BRIEF.md
# I2C Serial Memory Target

This block is an I2C target in front of an 8192-byte byte-wide memory array. It oversamples SCL and SDA with the system clock and finds START and STOP conditions. It checks the first byte after a START against a fixed four-bit type code and three select pins. A write header carries two address bytes that load a 13-bit address latch. Data bytes then stream into or out of the array, and the latch steps by one after each byte.

Writes take effect at once. A byte is stored on its eighth SCL rise, before the acknowledge, so a START or STOP before that bit discards the partial byte. There is no busy period after a write. A write-protect input turns away every data byte, and the latch stays where it is. A read always begins at the latch. A random read is a write header followed by a repeated START with the read bit set. SDA is an open-drain output: `sda_oe` high pulls the line low.

Top module: `i2c_mem_target`

## Requirements
- R1: A byte after START whose bits 7..4 are 1010 and whose bits 3..1 equal `dev_sel` is acknowledged, and bit 0 picks read (1) or write (0). This includes an address byte sent right after a completed write. Any other value gets no acknowledge, and the block ignores the bus until the next START or STOP.
- R2: After a write-direction device byte, the next two acknowledged bytes are the high and low halves of the address. Only the low 5 bits of the high byte are kept, which gives a 13-bit latch value.
- R3: With `wr_protect` low, each data byte is stored at the latch address on its eighth SCL rise and is acknowledged. The latch steps by one in the same clock.
- R4: The latch wraps from 1FFFh to 0000h, and one transfer may move any number of bytes.
- R5: A read starts at the latch, which is kept across STOP and repeated START. After a write header and a repeated START, the read begins at the newly loaded address.
- R6: A read sends 8 bits MSB first, then releases SDA for the master's acknowledge. On ACK the next sequential byte follows. On NACK the block releases SDA and goes idle.
- R7: A START or STOP before the eighth bit of a data byte leaves the array and the latch unchanged.
- R8: With `wr_protect` high, data bytes get no acknowledge, are not stored, and do not move the latch. Device and address bytes are still acknowledged.
- R9: Reset releases SDA and clears the latch to 0000h. The array contents are not cleared.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low |
| dev_sel | input | 3 | Select code that the device byte must match |
| wr_protect | input | 1 | High blocks all array writes |

## Verification
Storing a data byte and stepping the latch happen in the same clock, on the eighth SCL rise. When the latch holds 1FFFh, the wrap also happens in that clock. The bench provokes this with a burst that starts at 1FFEh. It then reads the range back, both through a random read across the boundary and through a current-address read after the burst. A byte that lands one place off, or a latch that does not wrap, shows up as a data mismatch against the bench's own memory and address model. The checker separately confirms that every change of the latch that is not a load is exactly one step.

// File: rtl/i2c_mem_pkg.sv
`timescale 1ns/1ps
package i2c_mem_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,      // ignoring the bus until START
    ST_RX,        // shifting in a byte
    ST_ACK_WAIT,  // byte done, wait for SCL low to answer
    ST_ACK,       // answer on the bus during ninth clock
    ST_TX,        // shifting out a byte
    ST_TX_REL,    // byte sent, release for master answer
    ST_MACK,      // sample master answer
    ST_MACK_END   // master acknowledged, load next byte at SCL low
  } tgt_state_e;

  typedef enum logic [1:0] {K_DEV, K_AHI, K_ALO, K_DATA} rx_kind_e;

  // Next latch value: one step up, wrapping inside aw bits.
  function automatic logic [31:0] addr_step(input logic [31:0] a, input int unsigned aw);
    logic [31:0] mask;
    mask = (32'd1 << aw) - 32'd1;
    return (a + 32'd1) & mask;
  endfunction

  // Device byte match: type nibble and select code.
  function automatic logic dev_hit(input logic [7:0] b, input logic [3:0] ty,
                                   input logic [2:0] sel);
    return (b[7:4] == ty) && (b[3:1] == sel);
  endfunction

  // Order of received bytes in a write header.
  function automatic rx_kind_e kind_after(input rx_kind_e k);
    case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_DATA;
    endcase
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_raw,
  input  logic sda_raw,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-1:0], scl_raw};
      sda_pipe <= {sda_pipe[STAGES-1:0], sda_raw};
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_d    = scl_pipe[STAGES];
  assign sda_d    = sda_pipe[STAGES];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mem_array.sv
`timescale 1ns/1ps
module i2c_mem_array #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_mem_target.sv
`timescale 1ns/1ps
module i2c_mem_target
  import i2c_mem_pkg::*;
#(
  parameter int         AW          = 13,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_oe,
  input  logic [2:0] dev_sel,
  input  logic       wr_protect
);
  localparam int HI_W = AW - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tgt_state_e      st_q;
  rx_kind_e        kind_q;
  logic [2:0]      bit_cnt_q;
  logic [7:0]      shreg_q;
  logic [HI_W-1:0] hi_q;
  logic [AW-1:0]   addr_q;
  logic            rw_q, ack_ok_q, oe_q;
  logic [7:0]      rd_data;

  // Named events shared with the checker
  logic [7:0] rx_byte;
  logic       byte_done, tx_done, dev_miss, mem_we, data_blk;
  logic       addr_load, addr_adv, mnack_ev, tgt_idle;

  assign rx_byte   = {shreg_q[6:0], sda_s};
  assign byte_done = (st_q == ST_RX) && scl_rise && (bit_cnt_q == 3'd7);
  assign tx_done   = (st_q == ST_TX) && scl_rise && (bit_cnt_q == 3'd7);
  assign dev_miss  = byte_done && (kind_q == K_DEV) && !dev_hit(rx_byte, DEV_TYPE, dev_sel);
  assign mem_we    = byte_done && (kind_q == K_DATA) && !wr_protect;
  assign data_blk  = byte_done && (kind_q == K_DATA) && wr_protect;
  assign addr_load = byte_done && (kind_q == K_ALO);
  assign addr_adv  = mem_we || tx_done;
  assign mnack_ev  = (st_q == ST_MACK) && scl_rise && sda_s;
  assign tgt_idle  = (st_q == ST_IDLE);

  i2c_mem_array #(.AW(AW), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(rx_byte), .rdata(rd_data)
  );

  // Address latch: loaded by the low address byte, stepped per byte moved
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         addr_q <= '0;
    else if (addr_load) addr_q <= {hi_q, rx_byte};
    else if (addr_adv)  addr_q <= AW'(addr_step(32'(addr_q), AW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      kind_q    <= K_DEV;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      hi_q      <= '0;
      rw_q      <= 1'b0;
      ack_ok_q  <= 1'b0;
      oe_q      <= 1'b0;
    end else if (start_ev) begin
      st_q      <= ST_RX;
      kind_q    <= K_DEV;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else if (stop_ev) begin
      st_q <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      case (st_q)
        ST_RX: if (scl_rise) begin
          shreg_q   <= rx_byte;
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            case (kind_q)
              K_DEV: begin
                if (dev_hit(rx_byte, DEV_TYPE, dev_sel)) begin
                  rw_q     <= rx_byte[0];
                  ack_ok_q <= 1'b1;
                  st_q     <= ST_ACK_WAIT;
                end else begin
                  st_q <= ST_IDLE;
                end
              end
              K_AHI: begin
                hi_q     <= rx_byte[HI_W-1:0];
                ack_ok_q <= 1'b1;
                st_q     <= ST_ACK_WAIT;
              end
              K_ALO: begin
                ack_ok_q <= 1'b1;
                st_q     <= ST_ACK_WAIT;
              end
              default: begin
                ack_ok_q <= !wr_protect;
                st_q     <= ST_ACK_WAIT;
              end
            endcase
          end
        end
        ST_ACK_WAIT: if (scl_fall) begin
          oe_q <= ack_ok_q;
          st_q <= ST_ACK;
        end
        ST_ACK: if (scl_fall) begin
          bit_cnt_q <= '0;
          if (kind_q == K_DEV && rw_q) begin
            shreg_q <= rd_data;
            oe_q    <= ~rd_data[7];
            st_q    <= ST_TX;
          end else begin
            oe_q   <= 1'b0;
            kind_q <= kind_after(kind_q);
            st_q   <= ST_RX;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) st_q <= ST_TX_REL;
          end else if (scl_fall) begin
            oe_q <= ~shreg_q[3'd7 - bit_cnt_q];
          end
        end
        ST_TX_REL: if (scl_fall) begin
          oe_q <= 1'b0;
          st_q <= ST_MACK;
        end
        ST_MACK: if (scl_rise) begin
          st_q <= sda_s ? ST_IDLE : ST_MACK_END;
        end
        ST_MACK_END: if (scl_fall) begin
          shreg_q   <= rd_data;
          oe_q      <= ~rd_data[7];
          bit_cnt_q <= '0;
          st_q      <= ST_TX;
        end
        default: ;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

module i2c_mem_target_chk
  import i2c_mem_pkg::*;
#(
  parameter int AW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic [AW-1:0] addr_q,
  input logic          addr_load,
  input logic          mem_we,
  input logic          data_blk,
  input logic          dev_miss,
  input logic          start_ev,
  input logic          mnack_ev,
  input logic          tgt_idle
);
  assert_miss_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_miss |=> tgt_idle);

  assert_commit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (addr_q == AW'(addr_step(32'($past(addr_q)), AW))));

  assert_only_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(addr_q) && !$past(addr_load)) |-> (addr_q == AW'(addr_step(32'($past(addr_q)), AW))));

  assert_nack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mnack_ev |=> (tgt_idle && !sda_oe));

  assert_start_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe);

  assert_protect_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    data_blk |=> $stable(addr_q));

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !$past(scl_s));
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .addr_q(addr_q),
  .addr_load(addr_load), .mem_we(mem_we), .data_blk(data_blk), .dev_miss(dev_miss),
  .start_ev(start_ev), .mnack_ev(mnack_ev), .tgt_idle(tgt_idle)
);

// File: tb/test_i2c_mem_target.sv
`timescale 1ns/1ps
module test_i2c_mem_target;
  localparam int DEPTH = 8192;
  localparam int QTR   = 10;   // clocks per quarter bus period
  localparam logic [2:0] SEL = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;

  always #2.5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_mem_target i_i2c_mem_target (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .sda_oe(sda_oe), .dev_sel(SEL), .wr_protect(wp)
  );

  int n_chk = 0, n_fail = 0, oe_viol = 0;
  bit done = 1'b0, reported = 1'b0;
  logic [7:0] mmem [int];   // bench memory model
  int maddr = 0;            // bench address latch model
  logic [7:0] wq[$];        // data bytes for the next write

  // Per-clock model of R10: SDA drive must stay put through a high SCL phase
  logic oe_p = 1'b0, scl_p1 = 1'b1, scl_p2 = 1'b1;
  always @(negedge clk) begin
    if (rst_n && m_scl && scl_p1 && scl_p2 && (sda_oe !== oe_p)) oe_viol++;
    oe_p   <= sda_oe;
    scl_p1 <= m_scl;
    scl_p2 <= scl_p1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
  endtask

  task automatic qw();
    repeat (QTR) @(negedge clk);
  endtask

  function automatic logic [7:0] dev_byte(input logic rd);
    return {4'b1010, SEL, rd};
  endfunction

  task automatic bus_start();
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; qw(); m_scl = 1'b1; qw(); ack = ~sda_line; qw(); m_scl = 1'b0; qw();
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); m_scl = 1'b1; qw(); d[i] = sda_line; qw(); m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1;
    qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
    m_sda = 1'b1;
  endtask

  // Header only: device byte (write) and two address bytes
  task automatic header(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    bus_start();
    wr_byte(dev_byte(1'b0), a); chk({req, " dev ack"}, a, 1);
    wr_byte(hi, a);             chk({req, " addr-hi ack"}, a, 1);
    wr_byte(lo, a);             chk({req, " addr-lo ack"}, a, 1);
    maddr = {hi, lo} & (DEPTH - 1);
  endtask

  task automatic tx_write(input logic [7:0] hi, input logic [7:0] lo, input string req);
    logic a;
    header(hi, lo, req);
    foreach (wq[i]) begin
      wr_byte(wq[i], a);
      chk({req, " data ack"}, a, !wp);
      if (!wp) begin
        mmem[maddr] = wq[i];
        maddr = (maddr + 1) % DEPTH;
      end
    end
    bus_stop();
  endtask

  task automatic read_body(input int n, input string req);
    logic a;
    logic [7:0] d;
    wr_byte(dev_byte(1'b1), a); chk({req, " read dev ack"}, a, 1);
    for (int k = 0; k < n; k++) begin
      rd_byte(k != n - 1, d);
      chk({req, " read data"}, d, mmem[maddr]);
      maddr = (maddr + 1) % DEPTH;
    end
    qw();
    chk({req, " released after NACK (R6)"}, sda_oe, 0);
    bus_stop();
  endtask

  task automatic tx_read_cur(input int n, input string req);
    bus_start();
    read_body(n, req);
  endtask

  task automatic tx_read_at(input logic [7:0] hi, input logic [7:0] lo, input int n,
                            input string req);
    header(hi, lo, req);
    bus_start();
    read_body(n, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic a;
    repeat (5) @(negedge clk);
    chk("R9 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R9 oe after reset", sda_oe, 0);

    // R9: latch returns to 0000h on reset, array keeps contents
    wq = '{8'h5A};
    tx_write(8'h00, 8'h00, "R3 single byte at 0000");
    @(negedge clk) rst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9 oe during second reset", sda_oe, 0);
    rst_n = 1'b1;
    maddr = 0;
    repeat (4) @(negedge clk);
    tx_read_cur(1, "R9 latch cleared");

    // R1: mismatching select code and type code
    bus_start();
    wr_byte({4'b1010, 3'b011, 1'b0}, a); chk("R1 wrong select NACK", a, 0);
    wr_byte(8'h00, a);                   chk("R1 idle after miss", a, 0);
    bus_stop();
    bus_start();
    wr_byte({4'b1011, SEL, 1'b0}, a);    chk("R1 wrong type NACK", a, 0);
    bus_stop();

    // R2/R3/R5: single write then random read
    wq = '{8'hA5};
    tx_write(8'h01, 8'h23, "R3 single write");
    bus_start();
    wr_byte(dev_byte(1'b0), a); chk("R1 poll right after write", a, 1);
    bus_stop();
    tx_read_at(8'h01, 8'h23, 1, "R5 random read");
    tx_read_at(8'hE1, 8'h23, 1, "R2 high bits ignored");

    // R4: burst across the top of the array, then reads across it
    wq = '{8'h10, 8'h21, 8'h32, 8'h43, 8'h54, 8'h65};
    tx_write(8'h1F, 8'hFE, "R4 wrap write");
    tx_read_at(8'h1F, 8'hFE, 5, "R4 wrap read R6 burst");
    tx_read_cur(1, "R5 current address");

    // R7: aborted data bytes
    wq = '{8'h11};
    tx_write(8'h00, 8'h40, "R7 setup");
    header(8'h00, 8'h40, "R7 stop abort");
    send_bits(8'h99, 5);
    bus_stop();
    tx_read_cur(1, "R7 stop abort unchanged");
    header(8'h00, 8'h40, "R7 restart abort");
    send_bits(8'h77, 6);
    bus_start();
    read_body(1, "R7 restart abort unchanged");

    // R8: write protect
    wq = '{8'h3C};
    tx_write(8'h00, 8'h50, "R8 setup");
    wp = 1'b1;
    wq = '{8'hC3, 8'h77};
    tx_write(8'h00, 8'h50, "R8 protected");
    wp = 1'b0;
    tx_read_cur(1, "R8 latch held and no write");
    tx_read_at(8'h00, 8'h51, 1, "R8 next cell");

    chk("R10 drive only while SCL low", oe_viol, 0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule